// File: doc/BRIEF.md
# Register Access Command Processor

This block takes control requests that arrive as a stream of 32-bit words, with network framing already removed, and turns each one into accesses on a simple register bus. The host can ask for a single write, a burst write to consecutive registers, a single read, a burst read, or a write that goes to every target at once. When the request has been carried out, the block sends back a reply stream. The reply starts with the request's identifier, so the host can pair each reply with the request it sent.

A request has this layout: identifier, operation code, address, word count, any data words, and a closing check word marked by `in_last`. The block XORs every word before the check word and compares the result with the check word. It holds incoming write data in a small buffer until that comparison is done, so a corrupted request never changes a register. The address has two fields. The upper `SEL_W` bits choose a target and are decoded to one-hot `bus_sel`. The lower bits give the register index, which goes up by one for each word of a burst. Reads are issued one at a time, and the data comes back on `bus_rdata` one cycle after `bus_re`.

Top module: `regcmd_engine`

## Requirements
- R1: Request words are taken in the order identifier, operation code, address, word count, data words, check word, with the check word carrying `in_last`. Every reply begins with the identifier of its request. `in_ready` is low from the check word until the reply's final word is accepted.
- R2: Operation code 1 writes the first data word to the addressed register with one `bus_we` pulse. The reply is identifier, status, check word, with status access count 1. The word count is ignored.
- R3: Operation code 2 writes data words to consecutive register indexes starting at the address. The number written is the smaller of the word count and the number of data words actually received. The status access count reports that number.
- R4: Operation code 3 reads one register and operation code 4 reads word-count consecutive registers. The reply is identifier, status, the read words in index order, then the check word.
- R5: Operation code 5 writes data words like code 2, but every bit of `bus_sel` is high on each write. Its reply carries identifier, status and check word only.
- R6: If the check word differs from the XOR of all earlier request words, no bus access happens. The status has bit 0 set and access count 0.
- R7: An operation code other than 1 to 5 causes no bus strobe. The status has bit 1 set and access count 0.
- R8: For codes 2, 4 and 5, a word count of 0 or larger than `MAX_BURST` causes no bus strobe. The status has bit 2 set and access count 0.
- R9: The status word is {access count in bits 31:16, zeros, bit 3 short, bit 2 count, bit 1 code, bit 0 check}. The last reply word is the XOR of all earlier reply words and is the only word with `out_last` high.
- R10: Each non-broadcast access drives exactly one `bus_sel` bit, given by address bits 31:32-`SEL_W`. Within a burst, the register index goes up by one per word and wraps inside its field.
- R11: A request that ends (`in_last`) within its first four words causes no bus access. Its reply carries the identifier and a status with only bit 3 set.
- R12: After reset, `in_ready` is high, and `out_valid`, `bus_we` and `bus_re` are low.
- R13: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request word valid |
| in_ready | output | 1 | Request word accepted when high with in_valid |
| in_data | input | 32 | Request word |
| in_last | input | 1 | Marks the check word ending a request |
| out_valid | output | 1 | Reply word valid |
| out_ready | input | 1 | Reply consumer ready |
| out_data | output | 32 | Reply word |
| out_last | output | 1 | Marks the reply's final check word |
| bus_sel | output | 2**SEL_W | One-hot target select, all ones for broadcast |
| bus_idx | output | 32-SEL_W | Register index within target |
| bus_wdata | output | 32 | Write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe, data expected one cycle later |
| bus_rdata | input | 32 | Read data |

## Verification
The hardest case to reach from the ports is a burst that ends inside the address field's wrap, combined with a burst cut short by an early check word. In both, the number of bus writes and the indexes they use differ from what the word count alone predicts. The stimulus sends a burst write that starts at the highest index of a target, and a burst write whose packet holds fewer data words than its word count. The bench logs every write strobe's index and select and compares them with the expected list, and it later reads the registers back to show which ones changed. A corrupted check word is sent on a write to a register that already holds a known value. This shows the buffered data was discarded and not written.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
   localparam int WORD_W = 32;

   localparam logic [WORD_W-1:0] OPC_WR_ONE  = 32'd1;
   localparam logic [WORD_W-1:0] OPC_WR_SEQ  = 32'd2;
   localparam logic [WORD_W-1:0] OPC_RD_ONE  = 32'd3;
   localparam logic [WORD_W-1:0] OPC_RD_SEQ  = 32'd4;
   localparam logic [WORD_W-1:0] OPC_WR_ALL  = 32'd5;

   localparam int FLG_CHECK = 0;
   localparam int FLG_CODE  = 1;
   localparam int FLG_COUNT = 2;
   localparam int FLG_SHORT = 3;

   typedef enum logic [3:0] {
      S_RX, S_CALC, S_WR, S_ID, S_STAT, S_RDI, S_RDW, S_RDH, S_TRL
   } eng_state_t;
endpackage

// File: rtl/regcmd_sel_dec.sv
module regcmd_sel_dec #(
   parameter int SEL_W = 2,
   localparam int NT = 1 << SEL_W
) (
   input  logic [SEL_W-1:0] field,
   input  logic             all_en,
   output logic [NT-1:0]    sel
);
   for (genvar g = 0; g < NT; g++) begin : g_tgt
      assign sel[g] = all_en || (field == SEL_W'(g));
   end
endmodule

// File: rtl/regcmd_wbuf.sv
module regcmd_wbuf #(
   parameter int DEPTH = 8,
   parameter int PTR_W = 3,
   parameter int W     = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [PTR_W-1:0] wptr,
   input  logic [W-1:0]     wdata,
   input  logic [PTR_W-1:0] rptr,
   output logic [W-1:0]     rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[wptr] <= wdata;
   end
   assign rdata = mem[rptr];

   p_wptr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(wptr) < DEPTH));
endmodule

// File: rtl/regcmd_rx.sv
module regcmd_rx
   import regcmd_pkg::*;
#(
   parameter int MAX_BURST = 8,
   parameter int CNT_W = 4,
   parameter int PTR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_last,
   output logic              pkt_end,
   output logic [WORD_W-1:0] hdr_id,
   output logic [WORD_W-1:0] hdr_op,
   output logic [WORD_W-1:0] hdr_addr,
   output logic [WORD_W-1:0] hdr_cnt,
   output logic [CNT_W-1:0]  nd,
   output logic              chk_err,
   output logic              short_err,
   output logic              wb_we,
   output logic [PTR_W-1:0]  wb_ptr,
   output logic [WORD_W-1:0] wb_data
);
   logic [2:0]        pos;
   logic [WORD_W-1:0] xacc;

   assign pkt_end = acc && in_last;
   assign wb_we   = acc && !in_last && (pos == 3'd4) && (nd < CNT_W'(MAX_BURST));
   assign wb_ptr  = nd[PTR_W-1:0];
   assign wb_data = in_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos       <= '0;
         xacc      <= '0;
         nd        <= '0;
         hdr_id    <= '0;
         hdr_op    <= '0;
         hdr_addr  <= '0;
         hdr_cnt   <= '0;
         chk_err   <= 1'b0;
         short_err <= 1'b0;
      end else if (acc) begin
         unique case (pos)
            3'd0: begin hdr_id <= in_data; nd <= '0; end
            3'd1: hdr_op   <= in_data;
            3'd2: hdr_addr <= in_data;
            3'd3: hdr_cnt  <= in_data;
            default: if (wb_we) nd <= nd + 1'b1;
         endcase
         if (in_last) begin
            pos       <= '0;
            xacc      <= '0;
            chk_err   <= (pos == 3'd4) && (xacc != in_data);
            short_err <= (pos != 3'd4);
         end else begin
            pos  <= (pos == 3'd4) ? 3'd4 : pos + 3'd1;
            xacc <= xacc ^ in_data;
         end
      end
   end

   p_nd_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      nd <= CNT_W'(MAX_BURST));
endmodule

// File: rtl/regcmd_engine.sv
module regcmd_engine
   import regcmd_pkg::*;
#(
   parameter int SEL_W     = 2,
   parameter int MAX_BURST = 8,
   localparam int NUM_TGT  = 1 << SEL_W,
   localparam int IDX_W    = WORD_W - SEL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [WORD_W-1:0]  in_data,
   input  logic               in_last,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [WORD_W-1:0]  out_data,
   output logic               out_last,
   output logic [NUM_TGT-1:0] bus_sel,
   output logic [IDX_W-1:0]   bus_idx,
   output logic [WORD_W-1:0]  bus_wdata,
   output logic               bus_we,
   output logic               bus_re,
   input  logic [WORD_W-1:0]  bus_rdata
);
   localparam int CNT_W = $clog2(MAX_BURST + 1);
   localparam int PTR_W = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;

   if (SEL_W < 1 || SEL_W > 8) begin : g_bad_sel
      $error("SEL_W out of range");
   end
   if (MAX_BURST < 1 || MAX_BURST > 4096) begin : g_bad_burst
      $error("MAX_BURST out of range");
   end

   eng_state_t        st;
   logic              acc, pkt_end, chk_err, short_err, wb_we;
   logic [WORD_W-1:0] hdr_id, hdr_op, hdr_addr, hdr_cnt, wb_data, buf_q;
   logic [CNT_W-1:0]  nd;
   logic [PTR_W-1:0]  wb_ptr;

   assign in_ready = (st == S_RX);
   assign acc      = in_valid && in_ready;

   regcmd_rx #(.MAX_BURST(MAX_BURST), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .acc(acc), .in_data(in_data), .in_last(in_last),
      .pkt_end(pkt_end), .hdr_id(hdr_id), .hdr_op(hdr_op), .hdr_addr(hdr_addr),
      .hdr_cnt(hdr_cnt), .nd(nd), .chk_err(chk_err), .short_err(short_err),
      .wb_we(wb_we), .wb_ptr(wb_ptr), .wb_data(wb_data));

   logic [CNT_W-1:0] dn_q, cnt_q;

   regcmd_wbuf #(.DEPTH(MAX_BURST), .PTR_W(PTR_W), .W(WORD_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .we(wb_we), .wptr(wb_ptr), .wdata(wb_data),
      .rptr(dn_q[PTR_W-1:0]), .rdata(buf_q));

   // operation decode, evaluated in S_CALC
   logic is_wr, is_rd, is_seq, is_all, code_bad, cnt_bad, any_err;
   logic [CNT_W-1:0] cnt_c, plan_cnt;

   always_comb begin
      is_wr = 1'b0; is_rd = 1'b0; is_seq = 1'b0; is_all = 1'b0; code_bad = 1'b0;
      unique case (hdr_op)
         OPC_WR_ONE: is_wr = 1'b1;
         OPC_WR_SEQ: begin is_wr = 1'b1; is_seq = 1'b1; end
         OPC_RD_ONE: is_rd = 1'b1;
         OPC_RD_SEQ: begin is_rd = 1'b1; is_seq = 1'b1; end
         OPC_WR_ALL: begin is_wr = 1'b1; is_seq = 1'b1; is_all = 1'b1; end
         default:    code_bad = 1'b1;
      endcase
      cnt_bad = is_seq && ((hdr_cnt == '0) || (hdr_cnt > WORD_W'(MAX_BURST)));
      any_err = chk_err || short_err || code_bad || cnt_bad;
      cnt_c   = hdr_cnt[CNT_W-1:0];
      if (any_err)               plan_cnt = '0;
      else if (is_wr && !is_seq) plan_cnt = (nd != '0) ? CNT_W'(1) : '0;
      else if (is_wr)            plan_cnt = (nd < cnt_c) ? nd : cnt_c;
      else if (!is_seq)          plan_cnt = CNT_W'(1);
      else                       plan_cnt = cnt_c;
   end

   logic [WORD_W-1:0] status_q, tx_xor, rd_hold;
   logic              err_q, all_q, rd_q;
   logic [SEL_W-1:0]  sel_q;
   logic [IDX_W-1:0]  base_q;
   logic              tx_fire, last_step;

   assign tx_fire   = out_valid && out_ready;
   assign last_step = ((dn_q + 1'b1) == cnt_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= S_RX; dn_q <= '0; cnt_q <= '0; status_q <= '0; tx_xor <= '0;
         rd_hold <= '0; err_q <= 1'b0; all_q <= 1'b0; rd_q <= 1'b0;
         sel_q <= '0; base_q <= '0;
      end else begin
         unique case (st)
            S_RX: if (pkt_end) st <= S_CALC;
            S_CALC: begin
               cnt_q    <= plan_cnt;
               err_q    <= any_err;
               all_q    <= is_all && !any_err;
               rd_q     <= is_rd && !any_err;
               sel_q    <= hdr_addr[WORD_W-1 -: SEL_W];
               base_q   <= hdr_addr[IDX_W-1:0];
               dn_q     <= '0;
               status_q <= {16'(plan_cnt), 12'd0, short_err,
                            cnt_bad && !short_err, code_bad && !short_err,
                            chk_err && !short_err};
               st <= (is_wr && !any_err && plan_cnt != '0) ? S_WR : S_ID;
            end
            S_WR: begin
               dn_q <= last_step ? '0 : dn_q + 1'b1;
               if (last_step) st <= S_ID;
            end
            S_ID: if (tx_fire) begin
               tx_xor <= tx_xor ^ out_data;
               st <= S_STAT;
            end
            S_STAT: if (tx_fire) begin
               tx_xor <= tx_xor ^ out_data;
               st <= (rd_q && cnt_q != '0) ? S_RDI : S_TRL;
            end
            S_RDI: st <= S_RDW;
            S_RDW: begin rd_hold <= bus_rdata; st <= S_RDH; end
            S_RDH: if (tx_fire) begin
               tx_xor <= tx_xor ^ out_data;
               dn_q <= last_step ? '0 : dn_q + 1'b1;
               st <= last_step ? S_TRL : S_RDI;
            end
            S_TRL: if (tx_fire) begin
               tx_xor <= '0;
               st <= S_RX;
            end
            default: st <= S_RX;
         endcase
      end
   end

   regcmd_sel_dec #(.SEL_W(SEL_W)) u_dec (
      .field(sel_q), .all_en(all_q), .sel(bus_sel));

   assign bus_idx   = base_q + IDX_W'(dn_q);
   assign bus_wdata = buf_q;
   assign bus_we    = (st == S_WR);
   assign bus_re    = (st == S_RDI);

   always_comb begin
      out_valid = 1'b1;
      out_last  = 1'b0;
      unique case (st)
         S_ID:    out_data = hdr_id;
         S_STAT:  out_data = status_q;
         S_RDH:   out_data = rd_hold;
         S_TRL:   begin out_data = tx_xor; out_last = 1'b1; end
         default: begin out_data = '0; out_valid = 1'b0; end
      endcase
   end

   p_rx_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !out_valid && !bus_we && !bus_re);
   p_bcast_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && all_q) |-> (&bus_sel));
   p_err_no_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we || bus_re) |-> !err_q);
   p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);
   p_sel_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_we || bus_re) && !all_q) |-> ($countones(bus_sel) == 1));
   p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/regcmd_engine_test.sv
module regcmd_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready, out_valid, out_last, bus_we, bus_re;
   logic [31:0] out_data, bus_wdata;
   logic [31:0] bus_rdata = '0;
   logic [3:0]  bus_sel;
   logic [29:0] bus_idx;

   always #4 clk = ~clk;

   regcmd_engine uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
      .bus_sel(bus_sel), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata));

   int compared = 0, mismatched = 0, strobes = 0, rcnt = 0;
   logic [31:0] mem    [4][16];
   logic [31:0] shadow [4][16];
   logic [31:0] pkt[$], rdq[$], exp_d[$];
   bit          exp_l[$];
   string       exp_t[$];
   logic [29:0] wlog_idx[$];
   logic [3:0]  wlog_sel[$];

   initial begin
      for (int t = 0; t < 4; t++)
         for (int i = 0; i < 16; i++) begin mem[t][i] = '0; shadow[t][i] = '0; end
   end

   // register file model
   always @(posedge clk) begin
      if (bus_we)
         for (int t = 0; t < 4; t++) if (bus_sel[t]) mem[t][bus_idx[3:0]] <= bus_wdata;
      if (bus_re)
         for (int t = 0; t < 4; t++) if (bus_sel[t]) bus_rdata <= mem[t][bus_idx[3:0]];
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: scoreboard pop and bus logging
   always @(negedge clk) begin
      rcnt++;
      out_ready = (rcnt % 4 != 1);
      if (rst_n && out_valid && out_ready) begin
         if (exp_d.size() == 0) chk(1'b0, "R1 unexpected reply word", out_data, '0);
         else begin
            logic [31:0] d; bit l; string tg;
            d = exp_d.pop_front(); l = exp_l.pop_front(); tg = exp_t.pop_front();
            chk(out_data == d && out_last == l, tg, {out_data[30:0], out_last}, {d[30:0], l});
         end
      end
      if (rst_n && (bus_we || bus_re)) strobes++;
      if (rst_n && bus_we) begin wlog_idx.push_back(bus_idx); wlog_sel.push_back(bus_sel); end
   end

   function automatic logic [31:0] stat(input int cnt, input logic [3:0] fl);
      return {16'(cnt), 12'd0, fl};
   endfunction

   function automatic logic [31:0] adr(input int t, input logic [29:0] i);
      return {2'(t), i};
   endfunction

   task automatic expect_reply(input logic [31:0] id, input logic [31:0] st, input string tg);
      logic [31:0] x;
      x = id ^ st;
      exp_d.push_back(id); exp_l.push_back(1'b0); exp_t.push_back({tg, " id R1"});
      exp_d.push_back(st); exp_l.push_back(1'b0); exp_t.push_back({tg, " status R9"});
      foreach (rdq[k]) begin
         exp_d.push_back(rdq[k]); exp_l.push_back(1'b0); exp_t.push_back({tg, " data R4"});
         x ^= rdq[k];
      end
      exp_d.push_back(x); exp_l.push_back(1'b1); exp_t.push_back({tg, " trailer R9"});
      rdq.delete();
   endtask

   task automatic drive(input logic [31:0] w, input bit l);
      in_valid = 1'b1; in_data = w; in_last = l;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   // send pkt queue; raw=1 sends as is, else appends check word (bad flips a bit)
   task automatic send(input bit raw, input bit bad);
      logic [31:0] x;
      x = '0;
      @(negedge clk);
      foreach (pkt[k]) x ^= pkt[k];
      for (int k = 0; k < pkt.size(); k++) drive(pkt[k], raw && (k == pkt.size() - 1));
      if (!raw) drive(bad ? (x ^ 32'h1) : x, 1'b1);
      pkt.delete();
      while (exp_d.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic rd_seq(input logic [31:0] id, input int t, input int i, input int n, input string tg);
      pkt = '{id, (n == 1) ? 32'd3 : 32'd4, adr(t, 30'(i)), 32'(n)};
      for (int k = 0; k < n; k++) rdq.push_back(shadow[t][(i + k) & 15]);
      expect_reply(id, stat(n, 4'b0000), tg);
      send(1'b0, 1'b0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R12 in_ready after reset", 32'(in_ready), 1);
      chk(out_valid == 1'b0, "R12 out_valid after reset", 32'(out_valid), 0);
      chk(!bus_we && !bus_re, "R12 bus idle after reset", {bus_we, bus_re}, 0);

      // R2 single write
      pkt = '{32'hA001, 32'd1, adr(1, 3), 32'd1, 32'hCAFE0001};
      shadow[1][3] = 32'hCAFE0001;
      expect_reply(32'hA001, stat(1, 4'b0000), "R2 single write");
      send(1'b0, 1'b0);
      rd_seq(32'hA002, 1, 3, 1, "R4 single read");

      // R3 burst write, R4 burst read
      pkt = '{32'hA003, 32'd2, adr(2, 5), 32'd4, 32'h11, 32'h22, 32'h33, 32'h44};
      shadow[2][5] = 32'h11; shadow[2][6] = 32'h22; shadow[2][7] = 32'h33; shadow[2][8] = 32'h44;
      expect_reply(32'hA003, stat(4, 4'b0000), "R3 burst write");
      send(1'b0, 1'b0);
      rd_seq(32'hA004, 2, 5, 4, "R4 burst read");

      // R3 early end: count 5, two data words
      pkt = '{32'hA005, 32'd2, adr(0, 0), 32'd5, 32'h55, 32'h66};
      shadow[0][0] = 32'h55; shadow[0][1] = 32'h66;
      expect_reply(32'hA005, stat(2, 4'b0000), "R3 early end");
      send(1'b0, 1'b0);
      rd_seq(32'hA006, 0, 0, 5, "R3 early end readback");

      // R6 bad check word
      pkt = '{32'hA007, 32'd1, adr(1, 3), 32'd1, 32'hDEAD0000};
      expect_reply(32'hA007, stat(0, 4'b0001), "R6 check error");
      send(1'b0, 1'b1);
      rd_seq(32'hA008, 1, 3, 1, "R6 register unchanged");

      // R7 unknown code
      begin
         int s0;
         s0 = strobes;
         pkt = '{32'hA009, 32'd9, adr(1, 3), 32'd1, 32'h77};
         expect_reply(32'hA009, stat(0, 4'b0010), "R7 unknown code");
         send(1'b0, 1'b0);
         chk(strobes == s0, "R7 no bus strobe", strobes, s0);

         // R8 bad counts
         s0 = strobes;
         pkt = '{32'hA00A, 32'd2, adr(1, 0), 32'd0, 32'h88};
         expect_reply(32'hA00A, stat(0, 4'b0100), "R8 count zero");
         send(1'b0, 1'b0);
         pkt = '{32'hA00B, 32'd4, adr(1, 0), 32'd9};
         expect_reply(32'hA00B, stat(0, 4'b0100), "R8 count too large");
         send(1'b0, 1'b0);
         chk(strobes == s0, "R8 no bus strobe", strobes, s0);

         // R11 short packet
         s0 = strobes;
         pkt = '{32'hA00C, 32'd1, adr(1, 3)};
         expect_reply(32'hA00C, stat(0, 4'b1000), "R11 short packet");
         send(1'b1, 1'b0);
         chk(strobes == s0, "R11 no bus strobe", strobes, s0);
      end

      // R5 broadcast
      wlog_idx.delete(); wlog_sel.delete();
      pkt = '{32'hA00D, 32'd5, adr(0, 7), 32'd2, 32'hE0, 32'hE1};
      for (int t = 0; t < 4; t++) begin shadow[t][7] = 32'hE0; shadow[t][8] = 32'hE1; end
      expect_reply(32'hA00D, stat(2, 4'b0000), "R5 broadcast");
      send(1'b0, 1'b0);
      chk(wlog_sel.size() == 2, "R5 write count", wlog_sel.size(), 2);
      foreach (wlog_sel[k]) chk(wlog_sel[k] == 4'hF, "R5 all selects", wlog_sel[k], 4'hF);
      for (int t = 0; t < 4; t++) rd_seq(32'hA010 + 32'(t), t, 7, 2, "R5 readback");

      // R10 index wrap and one-hot select
      wlog_idx.delete(); wlog_sel.delete();
      pkt = '{32'hA020, 32'd2, adr(3, 30'h3FFFFFFF), 32'd2, 32'h91, 32'h92};
      shadow[3][15] = 32'h91; shadow[3][0] = 32'h92;
      expect_reply(32'hA020, stat(2, 4'b0000), "R10 wrap burst");
      send(1'b0, 1'b0);
      chk(wlog_idx.size() == 2, "R10 write count", wlog_idx.size(), 2);
      if (wlog_idx.size() == 2) begin
         chk(wlog_idx[0] == 30'h3FFFFFFF, "R10 first index", 32'(wlog_idx[0]), 32'h3FFFFFFF);
         chk(wlog_idx[1] == 30'h0, "R10 wrapped index", 32'(wlog_idx[1]), 0);
         chk(wlog_sel[1] == 4'b1000, "R10 one-hot select", wlog_sel[1], 4'b1000);
      end
      rd_seq(32'hA021, 3, 15, 1, "R10 readback high");
      rd_seq(32'hA022, 3, 0, 1, "R10 readback wrap");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule